// File: doc/BRIEF.md
# Clock Source Switching Controller

This block chooses which oscillator drives the system clock. It starts on the internal oscillator and moves to an external one under software control, without an unsafe handover. Software sees two byte-wide control registers on a simple write/read bus. The internal register sets the internal oscillator's frequency code, its enable and the missing-clock detector enable, and carries the request to run from the external source. The external register sets the external oscillator's type and drive range. It also shows a read-only stability flag.

The external oscillator reports stability through an asynchronous valid input. That input passes through a two-flop synchroniser. It is then combined with a start-up timer that reloads on every write to the external register and runs for a parameterised count equal to 1 ms of system clock. Software writes the oscillator type, waits, polls the flag and sets the request. A request made too early is held pending and carried out once the flag becomes 1. The clock-select output drives an external glitch-free clock multiplexer. The analog oscillators sit outside the block.

Top module: `clk_src_switch`

## Requirements
- R1: After reset the internal register (address 0) reads 8'h14, the external register (address 1) reads 8'h00, `clkSelExt` is 0, `intFreqSel` is 2'b00, `intOscEn` is 1 and `missClkDetEn` is 0.
- R2: The internal register fields are as follows. Bits 1:0 drive `intFreqSel` (00, 01, 10, 11 for 2, 4, 8, 16 MHz nominal). Bit 2 is the oscillator enable. Bit 3 is the external-select request. Bit 7 drives `missClkDetEn`. Bits 6:4 are read-only and read 3'b001. A write shows on the outputs and on readback after the write edge.
- R3: The external register fields are as follows. Bits 2:0 are the drive code, shown on `extDrive`. Bits 6:4 are the oscillator type, shown on `extMode` (3'b110 crystal, 3'b111 crystal divided by two). Bit 3 reads 0. Bit 7 ignores writes.
- R4: Bit 7 of the external register follows `xoscValidAsync` two clock edges after the input changes, provided the other conditions of R5 and R6 hold.
- R5: A write to the external register holds bit 7 at 0 for exactly STARTUP_CYCLES clock edges, counted from the write edge, where STARTUP_CYCLES is CLK_FREQ_HZ/1000.
- R6: Bit 7 of the external register is 0 whenever the oscillator type field is 3'b000.
- R7: `clkSelExt` rises only on the edge after a cycle in which both the request bit and the valid flag are 1.
- R8: A request made while the valid flag is 0 leaves `clkSelExt` at 0. The switch happens automatically once the flag becomes 1.
- R9: Clearing the request bit returns `clkSelExt` to 0 on the next edge.
- R10: `intOscEn` equals the enable bit OR NOT `clkSelExt`. The internal oscillator cannot be switched off while it is the clock source.
- R11: Once `clkSelExt` is 1, it stays 1 while the request bit stays 1, even if the valid flag falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 internal, 1 external |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for the register at regAddr (combinational) |
| xoscValidAsync | input | 1 | Asynchronous external-oscillator stable indication |
| clkSelExt | output | 1 | Clock mux select: 1 selects the external source |
| intOscEn | output | 1 | Internal oscillator enable |
| intFreqSel | output | 2 | Internal oscillator frequency code |
| missClkDetEn | output | 1 | Missing-clock detector enable |
| extMode | output | 3 | External oscillator type code |
| extDrive | output | 3 | External oscillator drive/frequency-range code |

## Verification
Each result has a fixed due time:
- Register fields and the static outputs are due one edge after the write edge.
- The valid flag follows the asynchronous input after two edges.
- After an external write, the flag returns at the STARTUP_CYCLES-th edge.
- `clkSelExt` moves one edge after the cycle in which request and flag are both 1.

The bench drives on falling edges and samples just after them. It checks the cycle before each due edge as well as the due edge itself, so a result that arrives one edge early or late is caught.

// File: rtl/clk_sw_pkg.sv
package clk_sw_pkg;

  localparam int REG_W = 8;

  localparam logic ADDR_INT = 1'b0;
  localparam logic ADDR_EXT = 1'b1;

  // internal register field positions
  localparam int INT_FREQ_LO = 0;
  localparam int INT_FREQ_HI = 1;
  localparam int INT_EN_BIT  = 2;
  localparam int INT_REQ_BIT = 3;
  localparam int INT_MCD_BIT = 7;
  localparam logic [2:0] INT_RO_VAL = 3'b001;

  // external register field positions
  localparam int EXT_DRV_LO  = 0;
  localparam int EXT_DRV_HI  = 2;
  localparam int EXT_MODE_LO = 4;
  localparam int EXT_MODE_HI = 6;
  localparam int EXT_VLD_BIT = 7;

  localparam logic [1:0] INT_FREQ_RST = 2'b00;
  localparam logic       INT_EN_RST   = 1'b1;

  typedef struct packed {
    logic wrInt;
    logic wrExt;
    logic setSel;
    logic clrSel;
  } swStrobes_t;

  typedef enum logic [1:0] {
    SEL_INT  = 2'd0,
    SEL_PEND = 2'd1,
    SEL_EXT  = 2'd2
  } selState_t;

endpackage

// File: rtl/clk_sw_ctrl.sv
module clk_sw_ctrl
  import clk_sw_pkg::*;
#(
  parameter int STARTUP_CYCLES = 2000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regAddr,
  input  logic       selReq,
  input  logic       extModeNz,
  input  logic       xoscValidAsync,
  output swStrobes_t strobes,
  output logic       xoscValid
);

  localparam int CNT_W = $clog2(STARTUP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STARTUP_CYCLES);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       startCnt;
  logic                   timerDone;
  logic                   wrInt, wrExt;
  selState_t              state, stateNxt;
  logic                   setSel, clrSel;

  // synchroniser chain for the asynchronous valid input
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= xoscValidAsync;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], xoscValidAsync};
      end
    end
  endgenerate

  assign wrInt = regWrEn && (regAddr == ADDR_INT);
  assign wrExt = regWrEn && (regAddr == ADDR_EXT);

  // start-up timer: reloads on any write to the external register
  always_ff @(posedge clk) begin
    if (!rstN)               startCnt <= '0;
    else if (wrExt)          startCnt <= CNT_LOAD;
    else if (startCnt != '0) startCnt <= startCnt - 1'b1;
  end

  assign timerDone = (startCnt == '0);
  assign xoscValid = syncQ[SYNC_STAGES-1] && timerDone && extModeNz;

  // handover state machine
  always_comb begin
    stateNxt = state;
    setSel   = 1'b0;
    clrSel   = 1'b0;
    unique case (state)
      SEL_INT: begin
        if (selReq) begin
          if (xoscValid) begin
            setSel   = 1'b1;
            stateNxt = SEL_EXT;
          end else begin
            stateNxt = SEL_PEND;
          end
        end
      end
      SEL_PEND: begin
        if (!selReq) begin
          stateNxt = SEL_INT;
        end else if (xoscValid) begin
          setSel   = 1'b1;
          stateNxt = SEL_EXT;
        end
      end
      SEL_EXT: begin
        if (!selReq) begin
          clrSel   = 1'b1;
          stateNxt = SEL_INT;
        end
      end
      default: begin
        clrSel   = 1'b1;
        stateNxt = SEL_INT;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEL_INT;
    else       state <= stateNxt;
  end

  always_comb begin
    strobes        = '0;
    strobes.wrInt  = wrInt;
    strobes.wrExt  = wrExt;
    strobes.setSel = setSel;
    strobes.clrSel = clrSel;
  end

endmodule

// File: rtl/clk_sw_datapath.sv
module clk_sw_datapath
  import clk_sw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  swStrobes_t       strobes,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic             xoscValid,
  output logic [REG_W-1:0] regRdData,
  output logic             selReq,
  output logic             extModeNz,
  output logic             clkSelExt,
  output logic             intOscEn,
  output logic [1:0]       intFreqSel,
  output logic             missClkDetEn,
  output logic [2:0]       extMode,
  output logic [2:0]       extDrive
);

  logic [1:0] freqQ;
  logic       enQ, reqQ, mcdQ, selQ;
  logic [2:0] modeQ, drvQ;
  logic [REG_W-1:0] intView, extView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freqQ <= INT_FREQ_RST;
      enQ   <= INT_EN_RST;
      reqQ  <= 1'b0;
      mcdQ  <= 1'b0;
    end else if (strobes.wrInt) begin
      freqQ <= regWrData[INT_FREQ_HI:INT_FREQ_LO];
      enQ   <= regWrData[INT_EN_BIT];
      reqQ  <= regWrData[INT_REQ_BIT];
      mcdQ  <= regWrData[INT_MCD_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
      drvQ  <= '0;
    end else if (strobes.wrExt) begin
      modeQ <= regWrData[EXT_MODE_HI:EXT_MODE_LO];
      drvQ  <= regWrData[EXT_DRV_HI:EXT_DRV_LO];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               selQ <= 1'b0;
    else if (strobes.clrSel) selQ <= 1'b0;
    else if (strobes.setSel) selQ <= 1'b1;
  end

  always_comb begin
    intView = '0;
    intView[INT_FREQ_HI:INT_FREQ_LO] = freqQ;
    intView[INT_EN_BIT]  = enQ;
    intView[INT_REQ_BIT] = reqQ;
    intView[6:4]         = INT_RO_VAL;
    intView[INT_MCD_BIT] = mcdQ;
  end

  always_comb begin
    extView = '0;
    extView[EXT_DRV_HI:EXT_DRV_LO]   = drvQ;
    extView[EXT_MODE_HI:EXT_MODE_LO] = modeQ;
    extView[EXT_VLD_BIT]             = xoscValid;
  end

  assign regRdData    = (regAddr == ADDR_EXT) ? extView : intView;
  assign selReq       = reqQ;
  assign extModeNz    = (modeQ != 3'b000);
  assign clkSelExt    = selQ;
  assign intOscEn     = enQ | ~selQ;
  assign intFreqSel   = freqQ;
  assign missClkDetEn = mcdQ;
  assign extMode      = modeQ;
  assign extDrive     = drvQ;

endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import clk_sw_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 2_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       xoscValidAsync,
  output logic       clkSelExt,
  output logic       intOscEn,
  output logic [1:0] intFreqSel,
  output logic       missClkDetEn,
  output logic [2:0] extMode,
  output logic [2:0] extDrive
);

  localparam int STARTUP_CYCLES = (CLK_FREQ_HZ / 1000 < 1) ? 1 : CLK_FREQ_HZ / 1000;

  swStrobes_t strobes;
  logic       selReq;
  logic       extModeNz;
  logic       xoscValid;

  clk_sw_ctrl #(
    .STARTUP_CYCLES(STARTUP_CYCLES),
    .SYNC_STAGES   (SYNC_STAGES)
  ) i_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .regWrEn       (regWrEn),
    .regAddr       (regAddr),
    .selReq        (selReq),
    .extModeNz     (extModeNz),
    .xoscValidAsync(xoscValidAsync),
    .strobes       (strobes),
    .xoscValid     (xoscValid)
  );

  clk_sw_datapath i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .xoscValid   (xoscValid),
    .regRdData   (regRdData),
    .selReq      (selReq),
    .extModeNz   (extModeNz),
    .clkSelExt   (clkSelExt),
    .intOscEn    (intOscEn),
    .intFreqSel  (intFreqSel),
    .missClkDetEn(missClkDetEn),
    .extMode     (extMode),
    .extDrive    (extDrive)
  );

endmodule

// File: rtl/clk_src_switch_chk.sv
module clk_src_switch_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic       regAddr,
  input logic [7:0] regRdData,
  input logic       clkSelExt,
  input logic       intOscEn,
  input logic [2:0] extMode,
  input logic       selReq,
  input logic       xoscValid
);

  // R7: a rise of the select needs request and valid one cycle earlier
  a_r7_sel_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkSelExt) |-> $past(selReq && xoscValid));

  // R9: without a request the select is low on the next edge
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    !selReq |=> !clkSelExt);

  // R11: selection is held while the request stays set
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (clkSelExt && selReq) |=> clkSelExt);

  // R10: the internal oscillator is on while it is the source
  a_r10_int_on: assert property (@(posedge clk) disable iff (!rstN)
    !clkSelExt |-> intOscEn);

  // R6: no valid flag with the oscillator type off
  a_r6_mode_off: assert property (@(posedge clk) disable iff (!rstN)
    (extMode == 3'b000) |-> !xoscValid);

  // R5: the flag is low right after a write to the external register
  a_r5_restart: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr) |=> !xoscValid);

  // R2: read-only bits of the internal register
  a_r2_ro_bits: assert property (@(posedge clk) disable iff (!rstN)
    !regAddr |-> (regRdData[6:4] == 3'b001));

endmodule

bind clk_src_switch clk_src_switch_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .regRdData(regRdData),
  .clkSelExt(clkSelExt),
  .intOscEn (intOscEn),
  .extMode  (extMode),
  .selReq   (selReq),
  .xoscValid(xoscValid)
);

// File: tb/test_clk_src_switch.sv
`timescale 1ns/1ps
module test_clk_src_switch;

  localparam int CLK_HZ = 16_000;
  localparam int STARTUP = CLK_HZ / 1000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       xoscValidAsync = 1'b0;
  logic       clkSelExt, intOscEn, missClkDetEn;
  logic [1:0] intFreqSel;
  logic [2:0] extMode, extDrive;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clk_src_switch #(.CLK_FREQ_HZ(CLK_HZ)) i_clk_src_switch (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .xoscValidAsync(xoscValidAsync), .clkSelExt(clkSelExt),
    .intOscEn(intOscEn), .intFreqSel(intFreqSel),
    .missClkDetEn(missClkDetEn), .extMode(extMode), .extDrive(extDrive)
  );

  function automatic logic [7:0] expInt(input logic [7:0] d);
    return {d[7], 3'b001, d[3], d[2], d[1:0]};
  endfunction

  function automatic logic [7:0] expExt(input logic [7:0] d, input logic vld);
    return {vld, d[6:4], 1'b0, d[2:0]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    #1;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100_000 && !done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd4711));
    cyc(3);
    rstN = 1'b1;
    cyc(1);

    // R1 reset state
    rd(1'b0, r); chk("R1 int reg", r, 8'h14);
    rd(1'b1, r); chk("R1 ext reg", r, 8'h00);
    chk("R1 sel", {7'b0, clkSelExt}, 8'h00);
    chk("R1 freq", {6'b0, intFreqSel}, 8'h00);
    chk("R1 int en", {7'b0, intOscEn}, 8'h01);
    chk("R1 mcd", {7'b0, missClkDetEn}, 8'h00);

    // R2 internal fields; R10 enable forced while internal
    wr(1'b0, 8'h83);
    rd(1'b0, r); chk("R2 readback", r, 8'h93);
    chk("R2 freq 16MHz", {6'b0, intFreqSel}, 8'h03);
    chk("R2 mcd", {7'b0, missClkDetEn}, 8'h01);
    chk("R10 int en forced", {7'b0, intOscEn}, 8'h01);

    // R6 valid input with type off
    xoscValidAsync = 1'b1;
    cyc(4);
    rd(1'b1, r); chk("R6 flag with mode off", r, 8'h00);

    // R3 ext fields and R5 start-up window
    wr(1'b1, 8'hE7);
    rd(1'b1, r); chk("R3 readback", r, 8'h67);
    chk("R3 mode out", {5'b0, extMode}, 8'h06);
    chk("R3 drive out", {5'b0, extDrive}, 8'h07);
    for (int k = 1; k < STARTUP; k++) begin
      cyc(1);
      rd(1'b1, r);
      if (k == STARTUP - 1) chk("R5 flag low at last timer cycle", r, 8'h67);
      else if (r[7] !== 1'b0) chk("R5 flag low in window", r, 8'h67);
    end
    cyc(1);
    rd(1'b1, r); chk("R5 flag up at timer end", r, 8'hE7);

    // R4 synchroniser latency on falling input
    @(negedge clk); xoscValidAsync = 1'b0;
    cyc(1); rd(1'b1, r); chk("R4 still high after 1 edge", r, 8'hE7);
    cyc(1); rd(1'b1, r); chk("R4 low after 2 edges", r, 8'h67);

    // R8 pending request
    wr(1'b0, 8'h8B);
    rd(1'b0, r); chk("R2 request readback", r, 8'h9B);
    cyc(4);
    chk("R8 no switch while invalid", {7'b0, clkSelExt}, 8'h00);
    chk("R10 int en while pending", {7'b0, intOscEn}, 8'h01);
    @(negedge clk); xoscValidAsync = 1'b1;
    cyc(1); chk("R8 sel before flag", {7'b0, clkSelExt}, 8'h00);
    cyc(1); chk("R7 sel one edge after flag", {7'b0, clkSelExt}, 8'h00);
    cyc(1); chk("R7 R8 switched", {7'b0, clkSelExt}, 8'h01);
    chk("R10 int en off on external", {7'b0, intOscEn}, 8'h00);

    // R11 valid drop keeps selection
    @(negedge clk); xoscValidAsync = 1'b0;
    cyc(5);
    chk("R11 held after valid drop", {7'b0, clkSelExt}, 8'h01);

    // R9 clear request
    wr(1'b0, 8'h80);
    chk("R9 sel before clear edge", {7'b0, clkSelExt}, 8'h01);
    cyc(1);
    chk("R9 cleared", {7'b0, clkSelExt}, 8'h00);
    chk("R10 int en back", {7'b0, intOscEn}, 8'h01);

    // R7 immediate switch when already valid
    @(negedge clk); xoscValidAsync = 1'b1;
    cyc(3);
    wr(1'b0, 8'h08);
    chk("R7 not yet", {7'b0, clkSelExt}, 8'h00);
    cyc(1);
    chk("R7 switched next edge", {7'b0, clkSelExt}, 8'h01);

    // R11 ext rewrite while selected
    wr(1'b1, 8'h77);
    rd(1'b1, r); chk("R3 R5 rewrite readback", r, 8'h77);
    cyc(5);
    chk("R11 held across restart", {7'b0, clkSelExt}, 8'h01);

    wr(1'b0, 8'h04);
    cyc(1);
    chk("R9 cleared again", {7'b0, clkSelExt}, 8'h00);

    // random register traffic, request kept clear
    for (int n = 0; n < 40; n++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if (($urandom & 1) == 0) begin
        d[3] = 1'b0;
        wr(1'b0, d);
        rd(1'b0, r); chk("R2 random int", r, expInt(d));
        chk("R2 random freq", {6'b0, intFreqSel}, {6'b0, d[1:0]});
        chk("R10 random en", {7'b0, intOscEn}, 8'h01);
      end else begin
        wr(1'b1, d);
        rd(1'b1, r); chk("R3 random ext", r, expExt(d, 1'b0));
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule